// File: doc/BRIEF.md
# DDR2 Power-Down Entry and Exit Controller

This block sits between the command scheduler of a DDR2 memory controller and the device pins. It owns the clock-enable output. It watches every command the scheduler issues and keeps a guard counter for the earliest cycle at which clock enable may legally drop. When a power-down request is pending and the guard has run out, it lowers clock enable. It records whether any bank was open at that moment, which selects active or precharge power-down.

When the request is withdrawn, clock enable rises on the next edge. A ready flag then stays low for the exit delay before the scheduler may issue commands again. For active power-down, a static configuration bit selects a short or a long delay. Precharge power-down always uses the short delay. Each command type sets its own guard length, built from read latency, write latency, burst length, write-to-read turnaround, write recovery and the mode-register set delay. All of these are static inputs counted in clock cycles.

Commands and the request are plain control pins with no back-pressure. The only flow control is the `cmd_ready` flag. The scheduler must present a command only in a cycle where that flag is high. The power-down request is a level that stays pending until entry is legal.

Top module: `ddr2_pd_ctrl`

## Requirements
- R1: After reset, `cke` is 1, `cmd_ready` is 1, `pd_legal` is 1 and `pd_kind` is 1 (precharge).
- R2: `cmd_code` encodings and their guard lengths N are as follows. Read (2) and read with auto-precharge (3) give RL + BL/2. Write (4) gives WL + BL/2 + tWTR. Write with auto-precharge (5) gives WL + BL/2 + WR. Mode-register set (9) gives tMRD. Activate (1), precharge (6), precharge-all (7) and refresh (8) give 0. NOP (0) does nothing.
- R3: A command is taken at a rising edge k with `cmd_valid`=1. If `pd_req` stays high and no further command arrives, `cke` is first sampled low after edge k+N+1. `pd_legal` is low in the cycle right after a command with N>0.
- R4: A later command loads the guard only if its N is greater than the remaining count. Otherwise the remaining count keeps running down.
- R5: While `pd_req` is low, `cke` stays high, whatever the guard state.
- R6: At entry, `pd_kind` becomes 0 (active) if any bank is open and 1 (precharge) if none is.
- R7: Bank state follows the commands on `cmd_bank`. Activate opens that bank. Precharge, read with auto-precharge and write with auto-precharge close that bank. Precharge-all closes every bank.
- R8: While `cke` is low, dropping `pd_req` raises `cke` at the next edge.
- R9: After the edge that raises `cke`, `cmd_ready` stays low for exactly D cycles. D is tXARDS for active power-down with `cfg_slow_exit`=1. Otherwise D is tXARD.
- R10: `cmd_ready` is low in every cycle where `cke` is low.
- R11: `pd_kind` holds its value for the whole stay in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 4 | Command type (encoding in R2) |
| cmd_bank | input | BANK_W | Target bank of the command |
| pd_req | input | 1 | Level request to be in power-down |
| cfg_rl | input | LAT_W | Read latency (AL + CL), clocks |
| cfg_wl | input | LAT_W | Write latency, clocks |
| cfg_bl | input | LAT_W | Burst length, beats |
| cfg_twtr | input | LAT_W | Write-to-read turnaround, clocks |
| cfg_wr | input | LAT_W | Write recovery, clocks |
| cfg_tmrd | input | LAT_W | Mode-register set delay, clocks |
| cfg_txard | input | LAT_W | Fast exit delay, clocks |
| cfg_txards | input | LAT_W | Slow exit delay, clocks |
| cfg_slow_exit | input | 1 | Mode-register bit selecting slow exit from active power-down |
| cke | output | 1 | Clock enable to the device |
| cmd_ready | output | 1 | Scheduler may issue a command |
| pd_kind | output | 1 | Power-down flavour: 0 active, 1 precharge |
| pd_legal | output | 1 | Guard and exit timers are clear and the device is up |

## Verification
The assertions take for granted that the scheduler obeys `cmd_ready`. That means no command while `cke` is low or during the exit window, so only NOPs reach the device in power-down. They also assume the configuration inputs do not change while a guard or exit count is running. The stimulus issues each command only after it has seen `cmd_ready` high, and after every exit it waits for the flag to return. It changes `cfg_slow_exit` only while the device is up and idle. Each scenario lets the guard expire or enters and leaves power-down before the next scenario starts.

// File: rtl/ddr2_pd_pkg.sv
`timescale 1ns/1ps
package ddr2_pd_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_RDA  = 4'd3,
    CMD_WR   = 4'd4,
    CMD_WRA  = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_PREA = 4'd7,
    CMD_REF  = 4'd8,
    CMD_MRS  = 4'd9
  } cmd_e;

  typedef enum logic {
    PD_ACTIVE = 1'b0,
    PD_PRECHG = 1'b1
  } pd_kind_e;

  typedef enum logic {
    ST_UP   = 1'b0,
    ST_DOWN = 1'b1
  } pd_state_e;

endpackage

// File: rtl/ddr2_pd_need_calc.sv
`timescale 1ns/1ps
// Guard length required by one command (R2).
module ddr2_pd_need_calc
  import ddr2_pd_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int CNT_W = 6
) (
  input  logic [3:0]       cmd_code,
  input  logic [LAT_W-1:0] cfg_rl,
  input  logic [LAT_W-1:0] cfg_wl,
  input  logic [LAT_W-1:0] cfg_bl,
  input  logic [LAT_W-1:0] cfg_twtr,
  input  logic [LAT_W-1:0] cfg_wr,
  input  logic [LAT_W-1:0] cfg_tmrd,
  output logic [CNT_W-1:0] need
);

  localparam int PAD_W = CNT_W - LAT_W;

  function automatic logic [CNT_W-1:0] widen(input logic [LAT_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  logic [CNT_W-1:0] half_burst;
  logic [CNT_W-1:0] rd_need;
  logic [CNT_W-1:0] wr_base;

  always_comb begin
    half_burst = widen(cfg_bl) >> 1;
    rd_need    = widen(cfg_rl) + half_burst;
    wr_base    = widen(cfg_wl) + half_burst;
    case (cmd_code)
      CMD_RD, CMD_RDA: need = rd_need;
      CMD_WR:          need = wr_base + widen(cfg_twtr);
      CMD_WRA:         need = wr_base + widen(cfg_wr);
      CMD_MRS:         need = widen(cfg_tmrd);
      default:         need = '0;
    endcase
  end

endmodule

// File: rtl/ddr2_pd_guard.sv
`timescale 1ns/1ps
// Entry guard counter: reloads only on a longer requirement (R3, R4).
module ddr2_pd_guard #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] need,
  output logic             guard_zero
);

  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] remain_dec;
  logic [CNT_W-1:0] remain_nxt;

  always_comb begin
    remain_dec = (remain_q == '0) ? '0 : remain_q - 1'b1;
    remain_nxt = (load_en && (need > remain_dec)) ? need : remain_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain_q <= '0;
    else        remain_q <= remain_nxt;
  end

  assign guard_zero = (remain_q == '0);

endmodule

// File: rtl/ddr2_pd_bank_track.sv
`timescale 1ns/1ps
// Per-bank open/closed tracking (R6, R7).
module ddr2_pd_bank_track
  import ddr2_pd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              any_open
);

  logic [NUM_BANKS-1:0] open_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == BANK_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[g] <= 1'b0;
      end else if (cmd_valid) begin
        case (cmd_code)
          CMD_ACT:                   if (hit) open_q[g] <= 1'b1;
          CMD_PRE, CMD_RDA, CMD_WRA: if (hit) open_q[g] <= 1'b0;
          CMD_PREA:                  open_q[g] <= 1'b0;
          default:                   open_q[g] <= open_q[g];
        endcase
      end
    end
  end

  assign any_open = |open_q;

endmodule

// File: rtl/ddr2_pd_exit_timer.sv
`timescale 1ns/1ps
// Counts the exit-to-command window after clock enable rises (R9).
module ddr2_pd_exit_timer #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] dly,
  output logic             idle
);

  logic [LAT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= dly;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign idle = (left_q == '0);

endmodule

// File: rtl/ddr2_pd_ctrl.sv
`timescale 1ns/1ps
module ddr2_pd_ctrl
  import ddr2_pd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int LAT_W     = 4,
  parameter int CNT_W     = LAT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              pd_req,
  input  logic [LAT_W-1:0]  cfg_rl,
  input  logic [LAT_W-1:0]  cfg_wl,
  input  logic [LAT_W-1:0]  cfg_bl,
  input  logic [LAT_W-1:0]  cfg_twtr,
  input  logic [LAT_W-1:0]  cfg_wr,
  input  logic [LAT_W-1:0]  cfg_tmrd,
  input  logic [LAT_W-1:0]  cfg_txard,
  input  logic [LAT_W-1:0]  cfg_txards,
  input  logic              cfg_slow_exit,
  output logic              cke,
  output logic              cmd_ready,
  output logic              pd_kind,
  output logic              pd_legal
);

  pd_state_e        st_q;
  pd_kind_e         kind_q;
  logic             cmd_live;
  logic [CNT_W-1:0] need;
  logic             guard_zero;
  logic             any_open;
  logic             exit_idle;
  logic [LAT_W-1:0] exit_dly;
  logic             enter_go;
  logic             leave_go;

  assign cmd_live = cmd_valid && (cmd_code != CMD_NOP);

  ddr2_pd_need_calc #(.LAT_W(LAT_W), .CNT_W(CNT_W)) u_need (
    .cmd_code (cmd_code),
    .cfg_rl   (cfg_rl),
    .cfg_wl   (cfg_wl),
    .cfg_bl   (cfg_bl),
    .cfg_twtr (cfg_twtr),
    .cfg_wr   (cfg_wr),
    .cfg_tmrd (cfg_tmrd),
    .need     (need)
  );

  ddr2_pd_guard #(.CNT_W(CNT_W)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (cmd_live),
    .need       (need),
    .guard_zero (guard_zero)
  );

  ddr2_pd_bank_track #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_bank  (cmd_bank),
    .any_open  (any_open)
  );

  // Slow exit applies to active power-down only (R9).
  assign exit_dly = (kind_q == PD_ACTIVE && cfg_slow_exit) ? cfg_txards : cfg_txard;

  ddr2_pd_exit_timer #(.LAT_W(LAT_W)) u_exit (
    .clk   (clk),
    .rst_n (rst_n),
    .start (leave_go),
    .dly   (exit_dly),
    .idle  (exit_idle)
  );

  assign enter_go = (st_q == ST_UP) && pd_req && guard_zero && exit_idle && !cmd_live;
  assign leave_go = (st_q == ST_DOWN) && !pd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_UP;
      kind_q <= PD_PRECHG;
    end else if (enter_go) begin
      st_q   <= ST_DOWN;
      kind_q <= any_open ? PD_ACTIVE : PD_PRECHG;
    end else if (leave_go) begin
      st_q   <= ST_UP;
    end
  end

  assign cke       = (st_q == ST_UP);
  assign cmd_ready = (st_q == ST_UP) && exit_idle;
  assign pd_kind   = kind_q;
  assign pd_legal  = (st_q == ST_UP) && exit_idle && guard_zero;

endmodule

// File: rtl/ddr2_pd_ctrl_chk.sv
`timescale 1ns/1ps
module ddr2_pd_ctrl_chk #(
  parameter int LAT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [3:0]       cmd_code,
  input logic             pd_req,
  input logic             cke,
  input logic             cmd_ready,
  input logic             pd_kind,
  input logic             guard_zero,
  input logic [LAT_W-1:0] exit_dly
);

  // R10
  no_ready_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !cmd_ready);

  // R10
  cmd_only_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code != 4'd0) |-> cmd_ready);

  // R3
  legal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(pd_req) && $past(guard_zero)
                    && !$past(cmd_valid && cmd_code != 4'd0)));

  // R8
  prompt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !pd_req) |=> cke);

  // R9
  exit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke) && exit_dly != '0) |-> !cmd_ready);

  // R11
  kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$past(cke)) |-> $stable(pd_kind));

endmodule

bind ddr2_pd_ctrl ddr2_pd_ctrl_chk #(.LAT_W(LAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .pd_req     (pd_req),
  .cke        (cke),
  .cmd_ready  (cmd_ready),
  .pd_kind    (pd_kind),
  .guard_zero (guard_zero),
  .exit_dly   (exit_dly)
);

// File: tb/ddr2_pd_ctrl_tb.sv
`timescale 1ns/1ps
module ddr2_pd_ctrl_tb;

  localparam int BANK_W = 2;
  localparam int LAT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [3:0]        cmd_code = 4'd0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic              pd_req = 1'b0;
  logic [LAT_W-1:0]  cfg_rl = 4'd4, cfg_wl = 4'd3, cfg_bl = 4'd4, cfg_twtr = 4'd2;
  logic [LAT_W-1:0]  cfg_wr = 4'd3, cfg_tmrd = 4'd2, cfg_txard = 4'd2, cfg_txards = 4'd6;
  logic              cfg_slow_exit = 1'b0;
  logic              cke, cmd_ready, pd_kind, pd_legal;

  int checks = 0;
  int errors = 0;

  // Command codes (R2)
  localparam logic [3:0] C_ACT = 4'd1, C_RD = 4'd2, C_WR = 4'd4, C_WRA = 4'd5;
  localparam logic [3:0] C_PRE = 4'd6, C_PREA = 4'd7, C_REF = 4'd8, C_MRS = 4'd9;

  always #10 clk = ~clk;

  ddr2_pd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .pd_req(pd_req), .cfg_rl(cfg_rl), .cfg_wl(cfg_wl),
    .cfg_bl(cfg_bl), .cfg_twtr(cfg_twtr), .cfg_wr(cfg_wr), .cfg_tmrd(cfg_tmrd),
    .cfg_txard(cfg_txard), .cfg_txards(cfg_txards), .cfg_slow_exit(cfg_slow_exit),
    .cke(cke), .cmd_ready(cmd_ready), .pd_kind(pd_kind), .pd_legal(pd_legal)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] code, input logic [BANK_W-1:0] bank);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_bank = bank;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 4'd0;
  endtask

  task automatic issue_pair(input logic [3:0] c1, input logic [3:0] c2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c1; cmd_bank = '0;
    @(negedge clk);
    cmd_code = c2;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 4'd0;
  endtask

  // Called at the negedge after the command edge; counts edges until cke low.
  task automatic enter_pd(input int exp_n, input string tag);
    int n = 0;
    pd_req = 1'b1;
    do begin
      @(posedge clk); #1; n++;
    end while (cke && n < 100);
    check(n == exp_n + 1, tag, n, exp_n + 1);
    check(!cmd_ready, "R10 ready low in power-down", cmd_ready, 0);
  endtask

  task automatic exit_pd(input int exp_d, input string tag);
    int n = 0;
    @(negedge clk); pd_req = 1'b0;
    @(posedge clk); #1;
    check(cke, "R8 cke rises one edge after request drops", cke, 1);
    while (!cmd_ready && n < 100) begin
      n++; @(posedge clk); #1;
    end
    check(n == exp_d, tag, n, exp_d);
  endtask

  task automatic t_reset();
    #1;
    check(cke, "R1 cke after reset", cke, 1);
    check(cmd_ready, "R1 ready after reset", cmd_ready, 1);
    check(pd_legal, "R1 legal after reset", pd_legal, 1);
    check(pd_kind, "R1 kind after reset", pd_kind, 1);
  endtask

  task automatic t_activate();
    issue(C_ACT, 2'd0);
    enter_pd(0, "R3 entry after activate");
    check(pd_kind == 1'b0, "R6 active power-down with open bank", pd_kind, 0);
    exit_pd(2, "R9 fast exit from active power-down");
  endtask

  task automatic t_read_slow();
    issue(C_RD, 2'd0);
    check(!pd_legal, "R3 legal low right after read", pd_legal, 0);
    enter_pd(6, "R2 read guard RL+BL/2");
    @(negedge clk); cfg_slow_exit = 1'b1;
    exit_pd(6, "R9 slow exit from active power-down");
    cfg_slow_exit = 1'b0;
  endtask

  task automatic t_write();
    issue(C_WR, 2'd0);
    enter_pd(7, "R2 write guard WL+BL/2+tWTR");
    exit_pd(2, "R9 fast exit after write");
  endtask

  task automatic t_no_request();
    issue(C_RD, 2'd0);
    repeat (12) @(posedge clk);
    #1;
    check(cke, "R5 no entry without request", cke, 1);
    check(pd_legal, "R3 legal after guard expires", pd_legal, 1);
  endtask

  task automatic t_restart();
    issue_pair(C_RD, C_WRA);
    enter_pd(8, "R4 longer write-ap reloads guard");
    exit_pd(2, "R9 exit after restart test");
    issue(C_ACT, 2'd0);
    issue_pair(C_WRA, C_RD);
    enter_pd(7, "R4 shorter read keeps remaining count");
    check(pd_kind == 1'b1, "R7 write-ap closed the bank", pd_kind, 1);
    @(negedge clk); cfg_slow_exit = 1'b1;
    exit_pd(2, "R9 precharge power-down ignores slow bit");
    cfg_slow_exit = 1'b0;
  endtask

  task automatic t_banks();
    issue(C_ACT, 2'd0);
    issue(C_ACT, 2'd1);
    issue(C_PRE, 2'd0);
    enter_pd(0, "R3 entry after precharge");
    check(pd_kind == 1'b0, "R7 bank 1 still open after precharge of bank 0", pd_kind, 0);
    exit_pd(2, "R9 exit with bank open");
    issue(C_PREA, 2'd3);
    enter_pd(0, "R3 entry after precharge-all");
    check(pd_kind == 1'b1, "R7 precharge-all closes every bank", pd_kind, 1);
    exit_pd(2, "R9 exit from precharge power-down");
  endtask

  task automatic t_mrs_ref();
    issue(C_MRS, 2'd0);
    enter_pd(2, "R2 mode-register set guard tMRD");
    exit_pd(2, "R9 exit after mode set");
    issue(C_REF, 2'd0);
    enter_pd(0, "R2 refresh guard zero");
    repeat (5) @(posedge clk);
    #1;
    check(!cke, "R8 stays down while request held", cke, 0);
    exit_pd(2, "R9 exit after refresh");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_activate();
    t_read_slow();
    t_write();
    t_no_request();
    t_restart();
    t_banks();
    t_mrs_ref();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule